// File: doc/BRIEF.md
# Channel Busy Ratio Calculator

This block turns five free-running hardware activity counters into utilisation figures. The counters are total clock cycles, control-channel busy time, extension-channel busy time, receive-frame time and transmit-frame time. On each accepted sample strobe the block takes a snapshot of all five counters and forms the difference from the snapshot it kept from the previous strobe. It then derives four percentages of the cycle interval: control busy, extension busy, receive frame and transmit frame. It also derives an estimate of extension-channel occupancy measured against the time the control channel was idle.

The quotients come from one shared sequential divider, which produces one quotient bit per clock. A sample therefore takes a few hundred cycles. `busy_o` is high during that time, and any strobe that arrives while it is high is ignored. All results land together in one clock, marked by a single-cycle `done_o`, and stay steady until the next completion. A cycle counter that has gone backwards means the counters have saturated by shifting right, not wrapped. Such a sample, and the very first sample after reset, are reported as invalid with zero figures.

The controller has five states. IDLE waits for a strobe; the strobe takes the snapshot and moves to CHECK. CHECK classifies the sample. On saturation or a first sample it goes to PUBLISH. On a zero cycle interval it goes to LAUNCH at the extension estimate. Otherwise it goes to LAUNCH at the first percentage. LAUNCH starts a division and moves to WAIT; if the estimate's divisor is zero, it stores 100 and moves to PUBLISH. WAIT stores the quotient when the divider finishes. It then goes back to LAUNCH for the next operation, or to PUBLISH after the last one. PUBLISH drives the outputs and `done_o` and returns to IDLE.

Top module: `cbr_ratio_calc`

## Requirements
- R1: Each counter's interval value is its current value minus the snapshot taken at the previous accepted strobe, modulo 2^32, so a counter that rolls over still yields the true increment.
- R2: When the stored cycle snapshot is zero (first sample after reset) or greater than the current cycle value, both `pct_valid_o` and `ext_valid_o` are low and all five figures are zero.
- R3: Otherwise, with a nonzero cycle interval, each percentage is floor(interval × 100 / cycle interval), computed without overflow for any 32-bit intervals, and saturated at 255.
- R4: A zero cycle interval never reaches the divider: `pct_valid_o` is low and the four percentages are zero, while the extension estimate is still produced with `ext_valid_o` high.
- R5: Control idle time is the cycle interval minus the control busy interval when the cycle interval is larger, and zero otherwise.
- R6: The extension estimate is floor(extension busy interval × 100 / control idle time), reported as 100 when control idle time is zero, and never above 100.
- R7: Every accepted strobe replaces the whole snapshot, whether or not its result is valid.
- R8: A strobe while `busy_o` is high changes neither the snapshot nor the pending result.
- R9: All outputs change only in the cycle where `done_o` is high; `done_o` lasts exactly one cycle per accepted strobe.
- R10: After reset all outputs and flags are zero, `busy_o` is low and the snapshot is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Measurement strobe, taken only when idle |
| cyc_cnt_i | input | 32 | Total cycle counter |
| ctl_busy_cnt_i | input | 32 | Control-channel busy counter |
| ext_busy_cnt_i | input | 32 | Extension-channel busy counter |
| rx_frame_cnt_i | input | 32 | Receive-frame time counter |
| tx_frame_cnt_i | input | 32 | Transmit-frame time counter |
| busy_o | output | 1 | A sample is being processed |
| done_o | output | 1 | One-cycle pulse when results update |
| pct_valid_o | output | 1 | The four percentages are meaningful |
| ctl_pct_o | output | 8 | Control busy percentage |
| ext_pct_o | output | 8 | Extension busy percentage of all cycles |
| rxf_pct_o | output | 8 | Receive-frame percentage |
| txf_pct_o | output | 8 | Transmit-frame percentage |
| ext_valid_o | output | 1 | The extension estimate is meaningful |
| ext_est_o | output | 8 | Extension busy relative to control idle time, 0..100 |

## Verification
A snapshot that is wrongly updated or not updated is invisible on the sample where it happens. It shows as a wrong figure or wrong validity at the `done_o` of the next accepted strobe. A divider or operation-sequencing fault shows at the first `done_o` of the affected sample, as one figure out of place while the others are correct. A controller stuck outside IDLE shows as `done_o` never arriving. The reference model compares every output on every clock, so an output that moves without a completion pulse is caught in the same cycle.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int NCNT    = 5;
    localparam int IDX_CYC = 0;
    localparam int IDX_CTL = 1;
    localparam int IDX_EXT = 2;
    localparam int IDX_RXF = 3;
    localparam int IDX_TXF = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_LAUNCH,
        S_WAIT,
        S_PUBLISH
    } cbr_state_e;

endpackage

// File: rtl/cbr_snapshot.sv
module cbr_snapshot
    import cbr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take_i,
    input  logic [NCNT-1:0][CNT_W-1:0]  cur_i,
    output logic [NCNT-1:0][CNT_W-1:0]  prev_o,
    output logic [NCNT-1:0][CNT_W-1:0]  delta_o,
    output logic                        stale_o
);

    logic [NCNT-1:0][CNT_W-1:0] prev_q;
    logic [NCNT-1:0][CNT_W-1:0] delta_q;
    logic                       stale_q;

    for (genvar g = 0; g < NCNT; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g]  <= '0;
                delta_q[g] <= '0;
            end else if (take_i) begin
                prev_q[g]  <= cur_i[g];
                delta_q[g] <= cur_i[g] - prev_q[g];
            end
        end
    end

    // Stale: no earlier snapshot, or the cycle counter moved backwards.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stale_q <= 1'b0;
        end else if (take_i) begin
            stale_q <= (prev_q[IDX_CYC] == '0) || (prev_q[IDX_CYC] > cur_i[IDX_CYC]);
        end
    end

    assign prev_o  = prev_q;
    assign delta_o = delta_q;
    assign stale_o = stale_q;

    // R7: an accepted strobe leaves the cycle snapshot equal to the input.
    a_r7_snapshot_taken: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> prev_q[IDX_CYC] == $past(cur_i[IDX_CYC]));

endmodule

// File: rtl/cbr_seq_div.sv
module cbr_seq_div #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);

    localparam int STEP_W = $clog2(NUM_W + 1);
    localparam int CHK_W  = NUM_W + DEN_W;

    logic [NUM_W-1:0]  shf_q;
    logic [NUM_W-1:0]  num_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              done_q;

    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;
    logic              fits;
    logic [DEN_W-1:0]  rem_nxt;

    always_comb begin
        trial   = {rem_q, shf_q[NUM_W-1]};
        diff    = trial - {1'b0, den_q};
        fits    = trial >= {1'b0, den_q};
        rem_nxt = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q  <= '0;
            num_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start_i) begin
            shf_q  <= num_i;
            num_q  <= num_i;
            rem_q  <= '0;
            den_q  <= den_i;
            step_q <= STEP_W'(NUM_W);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            shf_q  <= {shf_q[NUM_W-2:0], fits};
            rem_q  <= rem_nxt;
            step_q <= step_q - 1'b1;
            if (step_q == STEP_W'(1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quo_o  = shf_q;

    logic [CHK_W-1:0] rebuilt;
    always_comb begin
        rebuilt = {{DEN_W{1'b0}}, shf_q} * {{NUM_W{1'b0}}, den_q}
                + {{NUM_W{1'b0}}, rem_q};
    end

    // R3: quotient and remainder rebuild the dividend exactly.
    a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rebuilt == {{DEN_W{1'b0}}, num_q}) && (rem_q < den_q));

endmodule

// File: rtl/cbr_ratio_calc.sv
module cbr_ratio_calc
    import cbr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PCT_W = 8,
    parameter int SCALE = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] cyc_cnt_i,
    input  logic [CNT_W-1:0] ctl_busy_cnt_i,
    input  logic [CNT_W-1:0] ext_busy_cnt_i,
    input  logic [CNT_W-1:0] rx_frame_cnt_i,
    input  logic [CNT_W-1:0] tx_frame_cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pct_valid_o,
    output logic [PCT_W-1:0] ctl_pct_o,
    output logic [PCT_W-1:0] ext_pct_o,
    output logic [PCT_W-1:0] rxf_pct_o,
    output logic [PCT_W-1:0] txf_pct_o,
    output logic             ext_valid_o,
    output logic [PCT_W-1:0] ext_est_o
);

    localparam int PROD_W  = CNT_W + $clog2(SCALE) + 1;
    localparam int NOP     = NCNT;
    localparam int OP_W    = $clog2(NOP);
    localparam int OP_EST  = NOP - 1;
    localparam int PCT_MAX = (1 << PCT_W) - 1;

    cbr_state_e state_q, state_d;

    logic [NCNT-1:0][CNT_W-1:0] cur_w;
    logic [NCNT-1:0][CNT_W-1:0] prev_w;
    logic [NCNT-1:0][CNT_W-1:0] delta_w;
    logic                       stale_w;
    logic                       take;

    assign cur_w[IDX_CYC] = cyc_cnt_i;
    assign cur_w[IDX_CTL] = ctl_busy_cnt_i;
    assign cur_w[IDX_EXT] = ext_busy_cnt_i;
    assign cur_w[IDX_RXF] = rx_frame_cnt_i;
    assign cur_w[IDX_TXF] = tx_frame_cnt_i;

    assign take = sample_i && (state_q == S_IDLE);

    cbr_snapshot #(.CNT_W(CNT_W)) u_snapshot (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .cur_i   (cur_w),
        .prev_o  (prev_w),
        .delta_o (delta_w),
        .stale_o (stale_w)
    );

    logic [CNT_W-1:0] cyc_d;
    logic [CNT_W-1:0] ctl_idle;
    logic             cyc_zero;

    always_comb begin
        cyc_d    = delta_w[IDX_CYC];
        cyc_zero = (cyc_d == '0);
        ctl_idle = (cyc_d > delta_w[IDX_CTL]) ? (cyc_d - delta_w[IDX_CTL]) : '0;
    end

    logic [OP_W-1:0]            op_q;
    logic [NOP-1:0][PCT_W-1:0]  res_q;
    logic                       pv_q;
    logic                       ev_q;
    logic                       last_op;
    logic                       skip_div;

    assign last_op  = (op_q == OP_W'(OP_EST));
    assign skip_div = last_op && (ctl_idle == '0);

    logic [CNT_W-1:0]  num_sel;
    logic [CNT_W-1:0]  div_den;
    logic [PROD_W-1:0] div_num;
    logic              div_start;
    logic              div_done;
    logic [PROD_W-1:0] div_quo;

    always_comb begin
        unique case (op_q)
            OP_W'(0): num_sel = delta_w[IDX_CTL];
            OP_W'(1): num_sel = delta_w[IDX_EXT];
            OP_W'(2): num_sel = delta_w[IDX_RXF];
            OP_W'(3): num_sel = delta_w[IDX_TXF];
            default:  num_sel = delta_w[IDX_EXT];
        endcase
        div_den   = last_op ? ctl_idle : cyc_d;
        div_num   = {{(PROD_W-CNT_W){1'b0}}, num_sel} * PROD_W'(SCALE);
        div_start = (state_q == S_LAUNCH) && !skip_div;
    end

    cbr_seq_div #(.NUM_W(PROD_W), .DEN_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    function automatic logic [PCT_W-1:0] limit(input logic [PROD_W-1:0] q,
                                               input logic [PROD_W-1:0] cap);
        return (q > cap) ? cap[PCT_W-1:0] : q[PCT_W-1:0];
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take) state_d = S_CHECK;
            S_CHECK:   state_d = stale_w ? S_PUBLISH : S_LAUNCH;
            S_LAUNCH:  state_d = skip_div ? S_PUBLISH : S_WAIT;
            S_WAIT:    if (div_done) state_d = last_op ? S_PUBLISH : S_LAUNCH;
            S_PUBLISH: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Working results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            res_q <= '0;
            pv_q  <= 1'b0;
            ev_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_CHECK: begin
                    res_q <= '0;
                    pv_q  <= !stale_w && !cyc_zero;
                    ev_q  <= !stale_w;
                    op_q  <= cyc_zero ? OP_W'(OP_EST) : '0;
                end
                S_LAUNCH: begin
                    if (skip_div) res_q[OP_EST] <= PCT_W'(SCALE);
                end
                S_WAIT: begin
                    if (div_done) begin
                        res_q[op_q] <= limit(div_quo, last_op ? PROD_W'(SCALE)
                                                              : PROD_W'(PCT_MAX));
                        if (!last_op) op_q <= op_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            pct_valid_o <= 1'b0;
            ext_valid_o <= 1'b0;
            ctl_pct_o   <= '0;
            ext_pct_o   <= '0;
            rxf_pct_o   <= '0;
            txf_pct_o   <= '0;
            ext_est_o   <= '0;
        end else begin
            done_o <= (state_q == S_PUBLISH);
            if (state_q == S_PUBLISH) begin
                pct_valid_o <= pv_q;
                ext_valid_o <= ev_q;
                ctl_pct_o   <= res_q[0];
                ext_pct_o   <= res_q[1];
                rxf_pct_o   <= res_q[2];
                txf_pct_o   <= res_q[3];
                ext_est_o   <= res_q[OP_EST];
            end
        end
    end

    assign busy_o = (state_q != S_IDLE);

    // R4: the divider never starts with a zero divisor.
    a_r4_no_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> div_den != '0);

    // R9: completion is a single-cycle pulse.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: figures hold steady outside a completion.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ctl_pct_o) && $stable(ext_pct_o) && $stable(rxf_pct_o)
                    && $stable(txf_pct_o) && $stable(ext_est_o) && $stable(pct_valid_o));

    // R2: a stale sample publishes zeros.
    a_r2_stale_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ext_valid_o) |-> (ctl_pct_o == '0) && (ext_pct_o == '0)
            && (rxf_pct_o == '0) && (txf_pct_o == '0) && (ext_est_o == '0));

    // R6: the estimate never exceeds full scale.
    a_r6_est_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid_o |-> ext_est_o <= PCT_W'(SCALE));

    // R8: a strobe while busy leaves the snapshot alone.
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sample_i) |=> $stable(prev_w));

endmodule

// File: tb/test_cbr_ratio_calc.sv
module test_cbr_ratio_calc;

    localparam int CLK_PERIOD = 10;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 1'b0;
    logic [31:0] cyc_cnt_i = '0, ctl_busy_cnt_i = '0, ext_busy_cnt_i = '0;
    logic [31:0] rx_frame_cnt_i = '0, tx_frame_cnt_i = '0;
    logic        busy_o, done_o, pct_valid_o, ext_valid_o;
    logic [7:0]  ctl_pct_o, ext_pct_o, rxf_pct_o, txf_pct_o, ext_est_o;

    cbr_ratio_calc i_cbr_ratio_calc (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .cyc_cnt_i(cyc_cnt_i), .ctl_busy_cnt_i(ctl_busy_cnt_i),
        .ext_busy_cnt_i(ext_busy_cnt_i), .rx_frame_cnt_i(rx_frame_cnt_i),
        .tx_frame_cnt_i(tx_frame_cnt_i), .busy_o(busy_o), .done_o(done_o),
        .pct_valid_o(pct_valid_o), .ctl_pct_o(ctl_pct_o), .ext_pct_o(ext_pct_o),
        .rxf_pct_o(rxf_pct_o), .txf_pct_o(txf_pct_o),
        .ext_valid_o(ext_valid_o), .ext_est_o(ext_est_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, n_cyc = 0;
    longint cnt[5];
    longint prev[5];
    longint cur_exp[7];
    longint pend_exp[7];
    bit     pending = 0;
    string  pend_tag = "";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic longint port_val(input int k);
        case (k)
            0: return longint'(pct_valid_o);
            1: return longint'(ctl_pct_o);
            2: return longint'(ext_pct_o);
            3: return longint'(rxf_pct_o);
            4: return longint'(txf_pct_o);
            5: return longint'(ext_valid_o);
            default: return longint'(ext_est_o);
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (done_o) begin
            check(pending, "R9", "done without accepted strobe", 1, longint'(pending));
            for (int k = 0; k < 7; k++)
                check(port_val(k) == pend_exp[k], pend_tag, $sformatf("field %0d", k),
                      port_val(k), pend_exp[k]);
            for (int k = 0; k < 7; k++) cur_exp[k] = pend_exp[k];
            pending = 0;
        end else begin
            for (int k = 0; k < 7; k++)
                if (port_val(k) != cur_exp[k])
                    check(0, "R9", $sformatf("field %0d moved", k), port_val(k), cur_exp[k]);
        end
    end

    function automatic longint minl(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    // Reference model for one accepted sample
    task automatic model(input string tag);
        longint d[5];
        longint idle;
        bit stale;
        stale = (prev[0] == 0) || (prev[0] > cnt[0]);
        for (int i = 0; i < 5; i++) d[i] = (cnt[i] - prev[i]) & MASK;
        for (int k = 0; k < 7; k++) pend_exp[k] = 0;
        if (!stale) begin
            if (d[0] != 0) begin
                pend_exp[0] = 1;
                for (int i = 1; i < 5; i++) pend_exp[i] = minl(d[i] * 100 / d[0], 255);
            end
            idle = (d[0] > d[1]) ? d[0] - d[1] : 0;
            pend_exp[5] = 1;
            pend_exp[6] = (idle == 0) ? 100 : minl(d[2] * 100 / idle, 100);
        end
        for (int i = 0; i < 5; i++) prev[i] = cnt[i];
        pend_tag = tag;
    endtask

    task automatic drive_cnt();
        cyc_cnt_i      = cnt[0][31:0];
        ctl_busy_cnt_i = cnt[1][31:0];
        ext_busy_cnt_i = cnt[2][31:0];
        rx_frame_cnt_i = cnt[3][31:0];
        tx_frame_cnt_i = cnt[4][31:0];
    endtask

    task automatic take(input string tag);
        while (busy_o) @(posedge clk);
        #1;
        drive_cnt();
        sample_i = 1'b1;
        model(tag);
        pending = 1;
        @(posedge clk); #1;
        sample_i = 1'b0;
        while (pending) @(posedge clk);
    endtask

    task automatic step(input longint a, input longint b, input longint c,
                        input longint e, input longint f, input string tag);
        cnt[0] = (cnt[0] + a) & MASK; cnt[1] = (cnt[1] + b) & MASK;
        cnt[2] = (cnt[2] + c) & MASK; cnt[3] = (cnt[3] + e) & MASK;
        cnt[4] = (cnt[4] + f) & MASK;
        take(tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) prev[i] = 0;
        for (int k = 0; k < 7; k++) cur_exp[k] = 0;
        pending = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin cnt[i] = 0; prev[i] = 0; end
        for (int k = 0; k < 7; k++) cur_exp[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state at the ports
        check(busy_o == 0 && done_o == 0, "R10", "busy/done in reset", busy_o, 0);
        check(ctl_pct_o == 0 && ext_est_o == 0 && pct_valid_o == 0 && ext_valid_o == 0,
              "R10", "outputs in reset", ext_est_o, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2: first sample after reset is stale
        cnt[0] = 1000; cnt[1] = 10; cnt[2] = 5; cnt[3] = 20; cnt[4] = 30;
        take("R2");
        // R3 R5 R6: ordinary sample
        step(1000, 250, 100, 333, 999, "R3");
        // R4: zero cycle interval, idle zero so estimate 100
        step(0, 40, 95, 0, 0, "R4");
        // R2: cycle counter goes backwards
        cnt[0] = 1500; take("R2");
        // R7: snapshot still taken on stale sample; estimate clamps R6
        step(100, 50, 60, 47, 71, "R7");
        // R1 R3: large intervals, one counter rolling over
        step(64'hF000_0000, 64'hE000_0000, 64'h0100_0000, 64'hFFFF_FF00, 64'hF000_0000, "R1");
        // R3: saturation at 255, R5 idle zero
        step(100, 300, 7, 1, 100, "R5");
        // R6: extension estimate below clamp
        step(1000, 600, 200, 0, 0, "R6");

        // R8: strobe during processing is ignored
        cnt[0] = (cnt[0] + 800) & MASK; cnt[1] = (cnt[1] + 200) & MASK;
        cnt[2] = (cnt[2] + 300) & MASK; cnt[3] = (cnt[3] + 80) & MASK;
        cnt[4] = (cnt[4] + 8) & MASK;
        while (busy_o) @(posedge clk);
        #1; drive_cnt(); sample_i = 1'b1; model("R8"); pending = 1;
        @(posedge clk); #1; sample_i = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        cyc_cnt_i = 32'hFFFF_FFFF; ctl_busy_cnt_i = 32'h0; sample_i = 1'b1;
        @(posedge clk); #1; sample_i = 1'b0;
        while (pending) @(posedge clk);
        step(400, 100, 30, 40, 4, "R8");

        // R10 then R2: mid-run reset clears the snapshot
        do_reset();
        step(500, 50, 10, 5, 5, "R10");
        step(200, 20, 18, 2, 200, "R1");

        repeat (5) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule